// File: doc/BRIEF.md
# Register Slave with Aliased Half-Backed Window

This block is a small memory-mapped register slave on an AXI4-Lite bus. Data is 32 bits wide. The decoder looks only at the low five address bits, which gives a 32-byte window. Any wider bus address folds back onto that window, so every 32-byte region of the bus address space reaches the same locations.

Only the lower half of the window, byte offsets 0x00 to 0x0F, has storage: four 32-bit words. The upper half, offsets 0x10 to 0x1F, takes writes on the bus and answers them normally, but the writes change nothing. Reads from the upper half return zero.

A write is taken only in a cycle where the address and the data are both valid. Both channels are then accepted together, and the write response appears in the next cycle. Each direction allows at most one outstanding response.

Top module: `axil_alias_regs`

## Requirements
- R1: After the active-low reset `rst_n` is released, `bvalid` and `rvalid` are low and all four storage words read back as zero.
- R2: `awready` and `wready` are always equal. They are high only in a cycle where `awvalid` and `wvalid` are both high and no write response is pending, so one channel alone is never accepted.
- R3: A write accepted at byte offset 0x00–0x0F updates word `awaddr[3:2]`. It changes byte i (bits 8i+7 down to 8i) only where `wstrb[i]` is 1, and leaves the other bytes and words untouched.
- R4: A write to offset 0x10–0x1F is accepted and answered, but no stored word changes. A read at offset 0x10–0x1F returns 0x00000000.
- R5: Only address bits [4:0] are decoded. An address and any other address with the same low five bits reach the same location.
- R6: `bvalid` rises in the cycle after a write is accepted and stays high until a cycle with `bready` high. No write is accepted while it is high. `bresp` is 2'b00 (OKAY) whenever `bvalid` is high.
- R7: `arready` is high exactly when no read response is pending. The read data appears with `rvalid` in the cycle after the address is accepted. `rvalid` and `rdata` stay unchanged until a cycle with `rready` high. `rresp` is 2'b00 (OKAY) whenever `rvalid` is high.
- R8: When a read and a write to the same word are accepted in the same cycle, the read returns the value the word held before that write.
- R9: `bvalid` never rises unless a write was accepted in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| awaddr | input | 12 | Write byte address (low 5 bits decoded) |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte enables for the write |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response taken |
| bresp | output | 2 | Write response code, always OKAY |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| araddr | input | 12 | Read byte address (low 5 bits decoded) |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data taken |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code, always OKAY |

## Verification
The bench goes after these corner cases:

- **One channel valid alone.** A design that accepted a lone address or lone data would raise one ready without the other and lose the pairing.
- **A write aimed at the empty upper half.** A design that decoded too few bits would overwrite a lower word.
- **Addresses above the window.** A design that compared the full address would drop or misroute the aliased accesses.
- **A read and a write to one word in the same cycle.** A design with the wrong ordering would return the new value.
- **Responses held back by low `bready` or `rready`.** A design that dropped `bvalid` or changed `rdata` early, or that accepted a new request while a response was still pending, is caught by the per-cycle comparison.

// File: rtl/axil_alias_pkg.sv
// Package: shared response codes and address helpers for the aliased
// register slave. Assumes byte addressing and a power-of-two data width.
package axil_alias_pkg;

    typedef enum logic [1:0] {
        RESP_OKAY = 2'b00
    } resp_e;

    // Number of address bits that select a byte inside one data word.
    function automatic int byte_shift(input int data_w);
        return $clog2(data_w / 8);
    endfunction

endpackage

// File: rtl/alias_wr_ctrl.sv
// Write channel control: accepts address and data together only when both
// are valid and no response is pending, then holds the response until taken.
// Assumes the register bank performs the write on the accept edge.
module alias_wr_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic awvalid,
    input  logic wvalid,
    input  logic bready,
    output logic accept,
    output logic bvalid
);

    // Joint accept: both channels valid and the response slot free.
    always_comb begin
        accept = awvalid && wvalid && !bvalid;
    end

    // Response flag: set by an accepted write, cleared when the master takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid <= 1'b0;
        end else if (accept) begin
            bvalid <= 1'b1;
        end else if (bready) begin
            bvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/alias_reg_bank.sv
// Register bank: WORDS words of DATA_W bits at the bottom of a 2**WIN_W byte
// window. Only the window bits of each address are decoded. Locations past
// the last word ignore writes and read as zero. Reads are combinational and
// see the contents before any write on the same edge.
module alias_reg_bank #(
    parameter int DATA_W = 32,
    parameter int WIN_W  = 5,
    parameter int WORDS  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [WIN_W-1:0]    waddr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic [WIN_W-1:0]    raddr,
    output logic [DATA_W-1:0]   rword
);

    localparam int BYTES = DATA_W / 8;
    localparam int BSH   = axil_alias_pkg::byte_shift(DATA_W);
    localparam int IDX_W = WIN_W - BSH;

    logic [DATA_W-1:0] mem [WORDS];
    logic [IDX_W-1:0]  widx;
    logic [IDX_W-1:0]  ridx;

    // Word index taken from the window bits above the byte lanes.
    always_comb begin
        widx = waddr[WIN_W-1:BSH];
        ridx = raddr[WIN_W-1:BSH];
    end

    // One storage word per generate step, each byte lane under its strobe.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < BYTES; b++) begin : g_lane
            // Byte lane register: cleared in reset, loaded when this word and lane are written.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[w][8*b +: 8] <= 8'h00;
                end else if (we && wstrb[b] && (int'(widx) == w)) begin
                    mem[w][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    end

    // Read mux: the selected backed word, zero for the unbacked part.
    always_comb begin
        rword = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (int'(ridx) == w) begin
                rword = mem[w];
            end
        end
    end

endmodule

// File: rtl/alias_rd_ctrl.sv
// Read channel control: takes one address at a time, registers the selected
// word and holds it with rvalid until the master takes it.
module alias_rd_ctrl #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    input  logic              rready,
    input  logic [DATA_W-1:0] rword,
    output logic              arready,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);

    // Address ready only while the single response slot is empty.
    always_comb begin
        arready = !rvalid;
    end

    // Response slot: capture on accept, release when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (arvalid && arready) begin
            rvalid <= 1'b1;
            rdata  <= rword;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/axil_alias_regs.sv
// Top: AXI4-Lite slave with a 2**WIN_W byte aliased window, of which only the
// lower WORDS words hold storage. The upper bus address bits are ignored.
// Assumes a single clock and a synchronous active-low reset.
module axil_alias_regs #(
    parameter int BUS_AW = 12,
    parameter int DATA_W = 32,
    parameter int WIN_W  = 5,
    parameter int WORDS  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                awvalid,
    output logic                awready,
    input  logic [BUS_AW-1:0]   awaddr,
    input  logic                wvalid,
    output logic                wready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    output logic                bvalid,
    input  logic                bready,
    output logic [1:0]          bresp,
    input  logic                arvalid,
    output logic                arready,
    input  logic [BUS_AW-1:0]   araddr,
    output logic                rvalid,
    input  logic                rready,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          rresp
);

    logic              wr_accept;
    logic [DATA_W-1:0] sel_word;
    logic              unused_hi;

    // Upper bus address bits play no part in decoding (aliasing).
    always_comb begin
        unused_hi = ^{awaddr[BUS_AW-1:WIN_W], araddr[BUS_AW-1:WIN_W]};
    end

    alias_wr_ctrl u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .awvalid (awvalid),
        .wvalid  (wvalid),
        .bready  (bready),
        .accept  (wr_accept),
        .bvalid  (bvalid)
    );

    alias_reg_bank #(
        .DATA_W (DATA_W),
        .WIN_W  (WIN_W),
        .WORDS  (WORDS)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_accept),
        .waddr (awaddr[WIN_W-1:0]),
        .wdata (wdata),
        .wstrb (wstrb),
        .raddr (araddr[WIN_W-1:0]),
        .rword (sel_word)
    );

    alias_rd_ctrl #(
        .DATA_W (DATA_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .arvalid (arvalid),
        .rready  (rready),
        .rword   (sel_word),
        .arready (arready),
        .rvalid  (rvalid),
        .rdata   (rdata)
    );

    // Both write channels share one ready; responses are always OKAY.
    always_comb begin
        awready = wr_accept;
        wready  = wr_accept;
        bresp   = axil_alias_pkg::RESP_OKAY;
        rresp   = axil_alias_pkg::RESP_OKAY;
    end

endmodule

// File: rtl/axil_alias_chk.sv
// Checker: protocol properties of the aliased register slave, bound to the top.
module axil_alias_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              awvalid,
    input logic              awready,
    input logic              wvalid,
    input logic              wready,
    input logic              bvalid,
    input logic              bready,
    input logic              arvalid,
    input logic              arready,
    input logic              rvalid,
    input logic              rready,
    input logic [DATA_W-1:0] rdata
);

    AST_JOINT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (awready == wready) && (!awready || (awvalid && wvalid))); // R2

    AST_RESP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        awready |=> bvalid); // R6

    AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid); // R6

    AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> !awready); // R6

    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (!bvalid && !awready) |=> !bvalid); // R9

    AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !arready); // R7

    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata))); // R7

    AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && arready) |=> rvalid); // R7

endmodule

bind axil_alias_regs axil_alias_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .awvalid (awvalid),
    .awready (awready),
    .wvalid  (wvalid),
    .wready  (wready),
    .bvalid  (bvalid),
    .bready  (bready),
    .arvalid (arvalid),
    .arready (arready),
    .rvalid  (rvalid),
    .rready  (rready),
    .rdata   (rdata)
);

// File: tb/sim_axil_alias_regs.sv
// Bench: behavioural reference model compared on every clock, plus directed
// checks per requirement and a random phase.
module sim_axil_alias_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [11:0] awaddr = '0, araddr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference model state.
    logic [31:0] m_mem [4];
    bit          m_bvalid = 0;
    bit          m_rvalid = 0;
    logic [31:0] m_rdata = '0;

    always #5 clk = ~clk;

    axil_alias_regs u0 (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .arvalid(arvalid), .arready(arready), .araddr(araddr),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [11:0] a);
        logic [4:0] off = a[4:0];
        return (off < 5'h10) ? m_mem[off[3:2]] : 32'h0;
    endfunction

    // Compare outputs against the model, then advance the model one clock.
    task automatic tick();
        bit acc, racc;
        #1;
        acc  = awvalid && wvalid && !m_bvalid;
        racc = arvalid && !m_rvalid;
        chk("R2", "awready", 32'(awready), 32'(acc));
        chk("R2", "wready", 32'(wready), 32'(acc));
        chk("R6", "bvalid", 32'(bvalid), 32'(m_bvalid));
        chk("R7", "arready", 32'(arready), 32'(!m_rvalid));
        chk("R7", "rvalid", 32'(rvalid), 32'(m_rvalid));
        if (m_rvalid) chk("R7", "rdata", rdata, m_rdata);
        if (m_bvalid) chk("R6", "bresp", 32'(bresp), 32'h0);
        if (m_rvalid) chk("R7", "rresp", 32'(rresp), 32'h0);
        if (racc) begin
            m_rdata  = m_read(araddr);
            m_rvalid = 1;
        end else if (m_rvalid && rready) begin
            m_rvalid = 0;
        end
        if (acc) begin
            if (awaddr[4:0] < 5'h10) begin
                for (int b = 0; b < 4; b++)
                    if (wstrb[b]) m_mem[awaddr[3:2]][8*b +: 8] = wdata[8*b +: 8];
            end
            m_bvalid = 1;
        end else if (m_bvalid && bready) begin
            m_bvalid = 0;
        end
        @(negedge clk);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        awvalid = 1; wvalid = 1; awaddr = a; wdata = d; wstrb = s;
        tick();
        awvalid = 0; wvalid = 0; bready = 1;
        tick();
        bready = 0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        arvalid = 1; araddr = a;
        tick();
        arvalid = 0; rready = 1;
        #1 d = rdata;
        tick();
        rready = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 4; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1;
        chk("R1", "bvalid after reset", 32'(bvalid), 32'h0);
        chk("R1", "rvalid after reset", 32'(rvalid), 32'h0);
        tick();
        for (int i = 0; i < 4; i++) begin
            do_read(12'(4 * i), d);
            chk("R1", "word after reset", d, 32'h0);
        end

        // R2: one channel alone is never accepted
        awvalid = 1; awaddr = 12'h000;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R2", "lone address ready", 32'(awready), 32'h0);
            tick();
        end
        awvalid = 0; wvalid = 1; wdata = 32'hDEAD0000; wstrb = 4'hF;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R2", "lone data ready", 32'(wready), 32'h0);
            tick();
        end
        wvalid = 0;
        tick();
        do_read(12'h000, d);
        chk("R2", "no write from lone channel", d, 32'h0);

        // R3: byte strobes
        do_write(12'h000, 32'h11223344, 4'hF);
        do_read(12'h000, d);
        chk("R3", "full word write", d, 32'h11223344);
        do_write(12'h000, 32'hAABBCCDD, 4'b0101);
        do_read(12'h000, d);
        chk("R3", "partial strobe", d, 32'h11BB33DD);
        do_write(12'h00C, 32'hCAFEF00D, 4'hF);
        do_read(12'h00C, d);
        chk("R3", "word 3 write", d, 32'hCAFEF00D);
        do_write(12'h004, 32'hFFFFFFFF, 4'h0);
        do_read(12'h004, d);
        chk("R3", "zero strobe", d, 32'h0);

        // R4: upper half
        do_write(12'h010, 32'hFFFFFFFF, 4'hF);
        do_read(12'h010, d);
        chk("R4", "upper read zero", d, 32'h0);
        do_read(12'h000, d);
        chk("R4", "word 0 kept", d, 32'h11BB33DD);
        do_write(12'h01C, 32'h0BADBEEF, 4'hF);
        do_read(12'h00C, d);
        chk("R4", "word 3 kept", d, 32'hCAFEF00D);

        // R5: aliasing
        do_write(12'h028, 32'h5A5A0001, 4'hF);
        do_read(12'h008, d);
        chk("R5", "alias write reaches 0x08", d, 32'h5A5A0001);
        do_read(12'hFE8, d);
        chk("R5", "alias read of 0x08", d, 32'h5A5A0001);
        do_write(12'h7F0, 32'h77777777, 4'hF);
        do_read(12'h030, d);
        chk("R5", "aliased upper reads zero", d, 32'h0);

        // R6: response held, no accept while pending
        awvalid = 1; wvalid = 1; awaddr = 12'h004; wdata = 32'h00000044; wstrb = 4'hF;
        tick();
        wdata = 32'h00000055; awaddr = 12'h008;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R6", "bvalid held", 32'(bvalid), 32'h1);
            chk("R6", "no accept while pending", 32'(awready), 32'h0);
            tick();
        end
        bready = 1;
        tick();
        tick();
        awvalid = 0; wvalid = 0;
        tick();
        bready = 0;
        do_read(12'h008, d);
        chk("R6", "second write after release", d, 32'h00000055);
        // R9: idle leaves bvalid low
        repeat (3) tick();
        chk("R9", "no spurious response", 32'(bvalid), 32'h0);

        // R7: read data held until taken
        arvalid = 1; araddr = 12'h000;
        tick();
        araddr = 12'h00C;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R7", "rdata held", rdata, 32'h11BB33DD);
            chk("R7", "arready low while pending", 32'(arready), 32'h0);
            tick();
        end
        arvalid = 0; rready = 1;
        tick();
        rready = 0;
        tick();

        // R8: same-cycle read and write of one word
        awvalid = 1; wvalid = 1; awaddr = 12'h004; wdata = 32'h12345678; wstrb = 4'hF;
        arvalid = 1; araddr = 12'h004;
        tick();
        awvalid = 0; wvalid = 0; arvalid = 0; bready = 1; rready = 1;
        #1 chk("R8", "read sees old value", rdata, 32'h00000044);
        tick();
        bready = 0; rready = 0;
        do_read(12'h004, d);
        chk("R8", "new value afterwards", d, 32'h12345678);

        // Random traffic against the model (R2 R3 R4 R5 R6 R7).
        for (int i = 0; i < 600; i++) begin
            awvalid = 1'($urandom); wvalid = 1'($urandom);
            bready = 1'($urandom); arvalid = 1'($urandom); rready = 1'($urandom);
            awaddr = 12'($urandom); araddr = 12'($urandom);
            wdata = $urandom; wstrb = 4'($urandom);
            tick();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule